// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer and Strobe Sequencer

This block turns one internal memory access that targets the DRAM region into the pin activity a page-mode DRAM expects. The address goes out on a narrow shared address bus in two halves. The row half goes out first and is latched by a falling row strobe. The column half follows and is latched by falling column strobes. There is one column strobe for each byte lane: the low strobe for the even byte and the high strobe for the odd byte. An active-low write strobe marks the access as a write.

A requester presents an address, a read/write flag and two byte enables with a one-cycle start pulse. The sequencer then runs a fixed series of states: row setup, row strobe, column setup, column strobe, hold and precharge. It raises a done pulse in the precharge cycle. The next access is accepted once the sequencer is back in idle.

A refresh request input is a level that the requester holds until the refresh acknowledge appears. A refresh runs a column-before-row cycle and only starts from idle, never in the middle of an access. If a start pulse and a pending refresh meet in idle, the access goes first.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While and right after reset, `busy`=0, `done`=0, `ref_ack`=0, `ras_n`=`casl_n`=`cash_n`=`dw_n`=1 and `ma`=0.
- R2: An access starts when `req_valid`=1 in idle and `req_be` is nonzero. In the cycle after the start edge, `ma` = row (`req_addr[2*MA_W-1:MA_W]`) and `ras_n`=1. In the following cycle `ras_n`=0 and `ma` still holds the row.
- R3: In the third cycle of an access, `ma` = column (`req_addr[MA_W-1:0]`), `ras_n`=0 and both column strobes are high. In the fourth cycle the enabled column strobes are low and `ma` is unchanged. `ma` is stable for at least one clock before every falling edge of `ras_n`, `casl_n` or `cash_n`.
- R4: Byte lanes: `req_be[0]`=1 drives `casl_n` low (even byte), `req_be[1]`=1 drives `cash_n` low (odd byte), and `req_be`=2'b11 drives both low.
- R5: A start pulse with `req_be`=2'b00 is ignored: `busy` stays 0 and no strobe moves.
- R6: For a write (`req_write`=1), `dw_n` is 0 from the third through the fifth cycle of the access, so it falls before and rises after the column strobes. For a read, `dw_n` stays 1. `dw_n` never changes on a column-strobe edge.
- R7: In the fifth cycle the column strobes are high again while `ras_n` stays 0. In the sixth cycle every strobe is high and `done`=1 for exactly one cycle. In the seventh cycle `busy`=0.
- R8: A refresh runs four cycles, with `dw_n`=1 and `ma`=0 throughout. In the first cycle both column strobes are low and `ras_n`=1. In the second, `ras_n`=0 with the column strobes still low. In the third, the column strobes are high and `ras_n`=0. In the fourth, all strobes are high and `ref_ack`=1.
- R9: A refresh request is only serviced from idle. A request raised during an access leaves that access unchanged and starts its refresh in the cycle after the access returns to idle. When a start pulse and a refresh request arrive together in idle, the access runs first.
- R10: `req_valid` pulses while `busy`=1 are ignored, and no second access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle start pulse for an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*MA_W | Internal address: row in the upper half, column in the lower half |
| req_be | input | 2 | Byte enables: bit 0 even lane, bit 1 odd lane |
| ref_req | input | 1 | Refresh request level, held until `ref_ack` |
| ma | output | MA_W | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Even-lane column strobe, active low |
| cash_n | output | 1 | Odd-lane column strobe, active low |
| dw_n | output | 1 | DRAM write strobe, active low |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle pulse ending an access |
| ref_ack | output | 1 | One-cycle pulse ending a refresh |

## Verification
Two things can reach the sequencer in the same idle cycle: an access start pulse and a pending refresh request. The bench drives both on one edge and checks two things. First, the next cycle must show the row on `ma` with `ras_n` high, and not the refresh pattern of both column strobes low. Second, after the access's done pulse, the refresh must begin exactly one idle cycle later. A second case raises the refresh request in the middle of an access and checks that every phase of that access keeps its expected values before the refresh follows.

// File: rtl/dram_mux_pkg.sv
// Package: shared state encoding and the byte-lane decode for the DRAM
// address multiplexer. Assumes a two-lane (16-bit) data path.
package dram_mux_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_ROW   = 4'd1,   // row on MA, row strobe high
        ST_RAS   = 4'd2,   // row strobe low
        ST_COL   = 4'd3,   // column on MA
        ST_CAS   = 4'd4,   // lane column strobes low
        ST_HOLD  = 4'd5,   // column strobes released, write strobe held
        ST_PRE   = 4'd6,   // all strobes high, done
        ST_RCAS  = 4'd7,   // refresh: column strobes first
        ST_RRAS  = 4'd8,   // refresh: row strobe follows
        ST_RREL  = 4'd9,   // refresh: column strobes released
        ST_RPRE  = 4'd10   // refresh: all high, acknowledge
    } seq_state_t;

    // Active-low column strobes {odd, even} for a set of byte enables.
    function automatic logic [1:0] lane_cas_n(input logic [1:0] be);
        return ~be;
    endfunction

endpackage

// File: rtl/dram_seq_fsm.sv
// Module: dram_seq_fsm
// Sequences one DRAM access (row, column, strobe, hold, precharge) or one
// column-before-row refresh. It latches the request at the start edge.
// Assumes req_valid is a pulse and ref_req is a level held until
// acknowledged. Refresh starts only from idle, and an access wins a tie.
module dram_seq_fsm
    import dram_mux_pkg::*;
#(
    parameter int MA_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [2*MA_W-1:0]     req_addr,
    input  logic [1:0]            req_be,
    input  logic                  ref_req,
    output seq_state_t            state,
    output logic [2*MA_W-1:0]     lat_addr,
    output logic [1:0]            lat_be,
    output logic                  lat_write
);
    seq_state_t nxt;
    logic       start;

    assign start = req_valid && (req_be != 2'b00);

    // Next-state selection; idle arbitration favours a new access.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)        nxt = ST_ROW;
                     else if (ref_req) nxt = ST_RCAS;
            ST_ROW:  nxt = ST_RAS;
            ST_RAS:  nxt = ST_COL;
            ST_COL:  nxt = ST_CAS;
            ST_CAS:  nxt = ST_HOLD;
            ST_HOLD: nxt = ST_PRE;
            ST_PRE:  nxt = ST_IDLE;
            ST_RCAS: nxt = ST_RRAS;
            ST_RRAS: nxt = ST_RREL;
            ST_RREL: nxt = ST_RPRE;
            ST_RPRE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Capture the request fields when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_be    <= 2'b00;
            lat_write <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            lat_addr  <= req_addr;
            lat_be    <= req_be;
            lat_write <= req_write;
        end
    end

    // R10
    busy_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_ROW, ST_RAS, ST_COL, ST_CAS, ST_HOLD}) |=> $stable(lat_addr) && $stable(lat_be));

    // R9
    ref_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RCAS) |-> ($past(state) == ST_IDLE));

endmodule

// File: rtl/dram_addr_mux.sv
// Module: dram_addr_mux
// Chooses what the shared MA pins carry: the row half during the row
// phases, the column half from column setup through precharge, and zero
// otherwise (idle and refresh). Assumes the row half is the upper half.
module dram_addr_mux
    import dram_mux_pkg::*;
#(
    parameter int MA_W = 9
) (
    input  seq_state_t            state,
    input  logic [2*MA_W-1:0]     lat_addr,
    output logic [MA_W-1:0]       ma
);
    logic [MA_W-1:0] row_part;
    logic [MA_W-1:0] col_part;

    assign row_part = lat_addr[2*MA_W-1:MA_W];
    assign col_part = lat_addr[MA_W-1:0];

    // Phase-dependent address selection.
    always_comb begin
        unique case (state)
            ST_ROW, ST_RAS:                 ma = row_part;
            ST_COL, ST_CAS, ST_HOLD, ST_PRE: ma = col_part;
            default:                        ma = '0;
        endcase
    end

endmodule

// File: rtl/dram_strobe_gen.sv
// Module: dram_strobe_gen
// Decodes the sequencer state into the active-low row, column-lane and
// write strobes, plus the done and refresh-acknowledge pulses. Assumes the
// state is registered, so the decoded outputs change only after clock edges.
module dram_strobe_gen
    import dram_mux_pkg::*;
(
    input  seq_state_t  state,
    input  logic [1:0]  lat_be,
    input  logic        lat_write,
    output logic        ras_n,
    output logic        casl_n,
    output logic        cash_n,
    output logic        dw_n,
    output logic        done,
    output logic        ref_ack
);
    logic [1:0] cas_pair_n;

    // Strobe levels for each state.
    always_comb begin
        ras_n      = 1'b1;
        cas_pair_n = 2'b11;
        dw_n       = 1'b1;
        done       = 1'b0;
        ref_ack    = 1'b0;
        unique case (state)
            ST_RAS:  ras_n = 1'b0;
            ST_COL:  begin ras_n = 1'b0; dw_n = ~lat_write; end
            ST_CAS:  begin ras_n = 1'b0; dw_n = ~lat_write; cas_pair_n = lane_cas_n(lat_be); end
            ST_HOLD: begin ras_n = 1'b0; dw_n = ~lat_write; end
            ST_PRE:  done = 1'b1;
            ST_RCAS: cas_pair_n = 2'b00;
            ST_RRAS: begin ras_n = 1'b0; cas_pair_n = 2'b00; end
            ST_RREL: ras_n = 1'b0;
            ST_RPRE: ref_ack = 1'b1;
            default: ;
        endcase
    end

    assign casl_n = cas_pair_n[0];
    assign cash_n = cas_pair_n[1];

endmodule

// File: rtl/dram_mux_ctrl.sv
// Module: dram_mux_ctrl (top)
// DRAM row/column address multiplexer with per-lane column strobes, a
// write strobe and column-before-row refresh. Assumes a 16-bit data path
// and a requester that waits for busy to fall before the next start pulse.
module dram_mux_ctrl
    import dram_mux_pkg::*;
#(
    parameter int MA_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [2*MA_W-1:0]     req_addr,
    input  logic [1:0]            req_be,
    input  logic                  ref_req,
    output logic [MA_W-1:0]       ma,
    output logic                  ras_n,
    output logic                  casl_n,
    output logic                  cash_n,
    output logic                  dw_n,
    output logic                  busy,
    output logic                  done,
    output logic                  ref_ack
);
    seq_state_t            state;
    logic [2*MA_W-1:0]     lat_addr;
    logic [1:0]            lat_be;
    logic                  lat_write;

    dram_seq_fsm #(.MA_W(MA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .ref_req(ref_req),
        .state(state), .lat_addr(lat_addr), .lat_be(lat_be), .lat_write(lat_write)
    );

    dram_addr_mux #(.MA_W(MA_W)) u_amux (
        .state(state), .lat_addr(lat_addr), .ma(ma)
    );

    dram_strobe_gen u_strb (
        .state(state), .lat_be(lat_be), .lat_write(lat_write),
        .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n), .dw_n(dw_n),
        .done(done), .ref_ack(ref_ack)
    );

    assign busy = (state != ST_IDLE);

    // R3
    ma_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) || $fell(casl_n) || $fell(cash_n)) |-> $stable(ma));

    // R6
    dw_stable_on_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(casl_n) || $changed(cash_n)) && (ras_n == 1'b0 || $past(ras_n) == 1'b0)
        && !ref_ack && $past(!ref_ack) |-> $stable(dw_n) || (casl_n && cash_n && $past(casl_n && cash_n)));

    // R8
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !casl_n) |-> ($past(casl_n) == 1'b0) && ($past(cash_n) == 1'b0));

    // R7
    done_strobes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ras_n && casl_n && cash_n && dw_n && !ref_ack);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ras_n && casl_n && cash_n && dw_n && (ma == '0));

endmodule

// File: tb/dram_mux_ctrl_bench.sv
module dram_mux_ctrl_bench;
    localparam int MA_W = 9;
    localparam int AW   = 2 * MA_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_be = 2'b00;
    logic [MA_W-1:0] ma;
    logic ras_n, casl_n, cash_n, dw_n, busy, done, ref_ack;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;   // 125 MHz

    dram_mux_ctrl #(.MA_W(MA_W)) u_dram_mux_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .ref_req(ref_req),
        .ma(ma), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n), .dw_n(dw_n),
        .busy(busy), .done(done), .ref_ack(ref_ack)
    );

    // Vector: {write, be[1:0], addr[17:0]}
    localparam int NV = 6;
    localparam logic [AW+2:0] VEC [0:NV-1] = '{
        {1'b0, 2'b01, 18'h2A5C3},
        {1'b0, 2'b10, 18'h1F00F},
        {1'b0, 2'b11, 18'h3FFFF},
        {1'b1, 2'b01, 18'h00155},
        {1'b1, 2'b10, 18'h12345},
        {1'b1, 2'b11, 18'h0AA01}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Pack strobes as {ras_n, cash_n, casl_n, dw_n}
    function automatic logic [31:0] strb();
        return {28'd0, ras_n, cash_n, casl_n, dw_n};
    endfunction

    // Start an access at a negedge; return at the negedge of its first cycle.
    task automatic launch(input logic wr, input logic [1:0] be, input logic [AW-1:0] a);
        req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Check the six access cycles, starting at the negedge of cycle 1.
    task automatic check_access(input logic wr, input logic [1:0] be, input logic [AW-1:0] a);
        logic [MA_W-1:0] row = a[AW-1:MA_W];
        logic [MA_W-1:0] col = a[MA_W-1:0];
        logic dwe = ~wr;
        chk("R2 row phase ma", ma, row);
        chk("R2 row phase strobes", strb(), {28'd0, 1'b1, 1'b1, 1'b1, 1'b1});
        @(negedge clk);
        chk("R2 ras low ma", ma, row);
        chk("R2 ras low strobes", strb(), {28'd0, 1'b0, 1'b1, 1'b1, 1'b1});
        @(negedge clk);
        chk("R3 column ma", ma, col);
        chk("R3/R6 column setup strobes", strb(), {28'd0, 1'b0, 1'b1, 1'b1, dwe});
        @(negedge clk);
        chk("R3 cas ma", ma, col);
        chk("R4/R6 cas lanes", strb(), {28'd0, 1'b0, ~be[1], ~be[0], dwe});
        @(negedge clk);
        chk("R7/R6 hold strobes", strb(), {28'd0, 1'b0, 1'b1, 1'b1, dwe});
        @(negedge clk);
        chk("R7 done pulse", {done, busy}, 2'b11);
        chk("R7 precharge strobes", strb(), {28'd0, 4'b1111});
        @(negedge clk);
        chk("R7 idle after access", {done, busy}, 2'b00);
    endtask

    // Check the four refresh cycles, starting at the negedge of refresh cycle 1.
    task automatic check_refresh();
        chk("R8 cbr cas first", strb(), {28'd0, 1'b1, 1'b0, 1'b0, 1'b1});
        chk("R8 ma zero", ma, 0);
        @(negedge clk);
        chk("R8 cbr ras", strb(), {28'd0, 1'b0, 1'b0, 1'b0, 1'b1});
        @(negedge clk);
        chk("R8 cbr cas release", strb(), {28'd0, 1'b0, 1'b1, 1'b1, 1'b1});
        @(negedge clk);
        chk("R8 cbr ack", {ref_ack, strb()[3:0]}, 5'b11111);
        ref_req = 1'b0;
        @(negedge clk);
        chk("R8 idle after refresh", {busy, ref_ack}, 2'b00);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset busy/done/ack", {busy, done, ref_ack}, 3'b000);
        chk("R1 reset strobes", strb(), {28'd0, 4'b1111});
        chk("R1 reset ma", ma, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {busy, strb()[3:0]}, 5'b01111);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            launch(VEC[i][AW+2], VEC[i][AW+1:AW], VEC[i][AW-1:0]);
            check_access(VEC[i][AW+2], VEC[i][AW+1:AW], VEC[i][AW-1:0]);
        end

        // R5: zero byte enables ignored
        launch(1'b1, 2'b00, 18'h3A5A5);
        chk("R5 be=00 ignored busy", busy, 0);
        chk("R5 be=00 ignored strobes", strb(), {28'd0, 4'b1111});
        @(negedge clk);
        chk("R5 be=00 still idle", busy, 0);

        // R8: plain refresh
        ref_req = 1'b1;
        @(negedge clk);
        check_refresh();

        // R9: access and refresh in the same idle cycle, access first
        ref_req = 1'b1;
        launch(1'b1, 2'b11, 18'h15A3C);
        check_access(1'b1, 2'b11, 18'h15A3C);   // ends at idle cycle 7
        @(negedge clk);
        check_refresh();

        // R9: refresh raised mid-access does not disturb it
        launch(1'b0, 2'b10, 18'h2F0F0);
        chk("R9 mid row ma", ma, 9'h178);
        @(negedge clk);
        ref_req = 1'b1;
        chk("R9 mid ras", strb(), {28'd0, 4'b0111});
        @(negedge clk);
        chk("R9 mid col ma", ma, 9'h0F0);
        @(negedge clk);
        chk("R9 mid cas lane", strb(), {28'd0, 4'b0011});
        repeat (2) @(negedge clk);
        chk("R9 mid done", done, 1);
        @(negedge clk);
        chk("R9 idle before refresh", busy, 0);
        @(negedge clk);
        check_refresh();

        // R10: start pulse while busy ignored
        launch(1'b0, 2'b01, 18'h00ABC);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 18'h3FE00; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 column unchanged", ma, 9'h0BC);
        @(negedge clk);
        chk("R10 lane unchanged", strb(), {28'd0, 4'b0101});
        repeat (3) @(negedge clk);
        chk("R10 no second access", busy, 0);
        @(negedge clk);
        chk("R10 still idle", {busy, strb()[3:0]}, 5'b01111);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule